// File: doc/BRIEF.md
# Microwire Serial Master Controller

This block is a half-duplex serial master for Microwire-style and SPI-style peripherals, driven by software through a small 16-bit register interface. Software writes a word into the transmit register and then issues one command. The command chooses one of up to four devices, says whether that device's select line is asserted, and gives a number of bits to send and a number of bits to receive. The block clocks out the send phase first and then clocks in the receive phase. A busy flag covers the whole transfer, and a data-ready flag marks that a received word is waiting.

Each device has its own setting for the launch edge, the sample edge, the select polarity and the serial clock divider. A global enable and prescaler produce the internal clock that the per-device divider divides again. A global bit sets the level of the serial clock at rest. The register index is shifted left by a parameterised stride to form the byte address, so the block fits both 8-bit and wider register strides.

Top module: `serial_mw_master`

## Requirements
- R1: The register index is `bus_addr >> ADDR_SHIFT`. Index 0 writes the transmit word and reads the receive word. Index 1 is command/status. Indices 2 and 3 hold device settings. Index 4 bit 0 is the clock enable and bits 2:1 are the prescale select. Index 5 bit 0 is the clock rest level. Setting registers read back what was written, and any other index reads 0.
- R2: A status read returns bit 15 = data ready, bit 14 = busy, bit 13 = 0, bit 12 = select command, bits 11:10 = device index, bits 9:5 = send count and bits 4:0 = receive count, all from the last accepted command.
- R3: In the send phase, the top N bits of the transmit word go out on `sdo` MSB first. `sdo` changes only on launch edges and holds steady on every opposite edge. Launch is on rising edges when device setting bit 1 is 1 and on falling edges when it is 0.
- R4: In the receive phase, `sdi` is sampled on N edges of the sample type: rising when device setting bit 0 is 1, falling when it is 0. The word lands LSB-aligned in the receive register with the upper bits zero.
- R5: A command with both counts nonzero runs the send phase and then the receive phase, with 2·(send+receive) serial clock edges in total. The serial clock ends at its rest level.
- R6: Each serial clock half period lasts P·D/2 input clock cycles. P is 2, 4, 7 or 10 for prescale select 0 to 3. D comes from device setting bits 4:3: 0 gives 2, 1 gives 4, and 2 or 3 gives 8.
- R7: While the clock enable is 0, no serial clock edge occurs and a started transfer waits. The transfer resumes once the enable is set.
- R8: When idle, `sclk` equals index 5 bit 0. Its reset value is 0.
- R9: `cs_out[i]` is active when the select command is 1 and the device index is i, with or without a start, and inactive otherwise. The active level is high when device setting bit 2 is 1 and low when it is 0. Device 0 uses index 2 bits 5:0, device 1 uses index 2 bits 11:6, and devices 2 and 3 use the same positions in index 3.
- R10: Busy rises the cycle after a start command (bit 13) with a nonzero count is accepted, and falls when shifting ends. A start with both counts zero leaves busy low and produces no clock edge.
- R11: Data ready sets when busy falls at the end of a receive phase. It clears when index 0 is read or when a new start command is accepted.
- R12: A command written while busy is ignored in every field.
- R13: A count above 16 is treated as 16, both for shifting and in the status readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_SHIFT+3 | Byte address of the register access |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of index 0 clears data ready) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sdi | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the device |
| cs_out | output | NUM_CS | Device selects, with per-device polarity |

## Verification
A vector table runs transfers that vary the device index, the launch and sample edges, the prescale and divider, the rest level, and the counts: send-only, receive-only, both phases, single-bit and over-length. A bench-side device model captures `sdo` on the edges opposite to launch and feeds `sdi` between sample edges. An edge on the wrong type therefore shows up as a shifted or corrupted word, a wrong edge count separates phase ordering from bit-count errors, and the measured gap between edges separates the prescale ratio from the divider. Directed cases cover select lines without a start, zero-count starts, a gated clock, commands written while busy, and both ways data ready is cleared.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RECV} mw_state_e;

   typedef struct packed {
      logic       chk_rdy;
      logic [1:0] div_sel;
      logic       cs_hi;
      logic       tx_rise;
      logic       rx_rise;
   } mw_cfg_t;

   function automatic logic [3:0] prescale_ratio(input logic [1:0] s);
      case (s)
         2'd0:    return 4'd2;
         2'd1:    return 4'd4;
         2'd2:    return 4'd7;
         default: return 4'd10;
      endcase
   endfunction

   function automatic logic [2:0] half_ticks(input logic [1:0] d);
      case (d)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/mw_prescale.sv
module mw_prescale (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] ratio_sel,
   output logic       tick
);
   import mw_pkg::*;

   logic [3:0] cnt_q;
   logic [3:0] ratio;

   assign ratio = prescale_ratio(ratio_sel);
   assign tick  = en && (cnt_q >= ratio - 4'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!en)    cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 4'd1;
   end

   // R6: internal ticks are never back to back (smallest ratio is 2)
   a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R7: a disabled prescaler produces no tick next cycle
   a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tick);

endmodule

// File: rtl/mw_shift_engine.sv
module mw_shift_engine #(
   parameter  int DATA_W = 16,
   localparam int CNT_W  = $clog2(DATA_W) + 1,
   localparam int EDGE_W = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              idle_pol,
   input  mw_pkg::mw_cfg_t   cfg,
   input  logic              start,
   input  logic [CNT_W-1:0]  send_bits,
   input  logic [CNT_W-1:0]  recv_bits,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              sdi,
   output logic              sclk,
   output logic              sdo,
   output logic              busy,
   output logic              rx_done,
   output logic [DATA_W-1:0] rx_word
);
   import mw_pkg::*;

   mw_state_e         state_q;
   logic [DATA_W-1:0] txsh_q, rxsh_q;
   logic [EDGE_W-1:0] edge_q, edge_lim;
   logic [2:0]        half_q, hlim;
   logic [CNT_W-1:0]  sn_q, rn_q, n_bits;
   logic              sclk_q, done_q;
   logic              half_end, last_edge, rising;

   assign n_bits    = (state_q == ST_SEND) ? sn_q : rn_q;
   assign edge_lim  = {n_bits, 1'b0} - {{CNT_W{1'b0}}, 1'b1};
   assign last_edge = (edge_q == edge_lim);
   assign hlim      = half_ticks(cfg.div_sel);
   assign half_end  = (half_q == hlim - 3'd1);
   assign rising    = ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         txsh_q  <= '0;
         rxsh_q  <= '0;
         edge_q  <= '0;
         half_q  <= '0;
         sn_q    <= '0;
         rn_q    <= '0;
         sclk_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state_q == ST_IDLE) begin
            sclk_q <= idle_pol;
            if (start) begin
               txsh_q <= tx_word;
               rxsh_q <= '0;
               edge_q <= '0;
               half_q <= '0;
               sn_q   <= send_bits;
               rn_q   <= recv_bits;
               if (send_bits != '0)      state_q <= ST_SEND;
               else if (recv_bits != '0) state_q <= ST_RECV;
            end
         end else if (tick) begin
            if (!half_end) begin
               half_q <= half_q + 3'd1;
            end else begin
               half_q <= '0;
               sclk_q <= ~sclk_q;
               edge_q <= last_edge ? '0 : edge_q + 1'b1;
               if (state_q == ST_SEND) begin
                  if (rising == cfg.tx_rise && edge_q != '0)
                     txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
                  if (last_edge)
                     state_q <= (rn_q != '0) ? ST_RECV : ST_IDLE;
               end else begin
                  if (rising == cfg.rx_rise)
                     rxsh_q <= {rxsh_q[DATA_W-2:0], sdi};
                  if (last_edge) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign sdo     = txsh_q[DATA_W-1];
   assign busy    = (state_q != ST_IDLE) || done_q;
   assign rx_done = done_q;
   assign rx_word = rxsh_q;

   // R7: the serial clock moves only on an internal tick
   a_r7_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !tick) |=> $stable(sclk_q));
   // R8: at rest the serial clock follows the programmed rest level
   a_r8_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |=> (sclk_q == $past(idle_pol)));

endmodule

// File: rtl/mw_cs_drive.sv
module mw_cs_drive #(
   parameter int NUM_CS = 4
) (
   input  logic              sel_on,
   input  logic [1:0]        sel_idx,
   input  logic [NUM_CS-1:0] hi_mask,
   output logic [NUM_CS-1:0] cs_out
);
   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      logic act;
      assign act       = sel_on && (sel_idx == 2'(i));
      assign cs_out[i] = hi_mask[i] ? act : ~act;
   end
endmodule

// File: rtl/serial_mw_master.sv
module serial_mw_master #(
   parameter  int DATA_W     = 16,
   parameter  int NUM_CS     = 4,
   parameter  int ADDR_SHIFT = 1,
   localparam int ADDR_W     = ADDR_SHIFT + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              sdi,
   output logic              sclk,
   output logic              sdo,
   output logic [NUM_CS-1:0] cs_out
);
   import mw_pkg::*;

   localparam int CNT_W = $clog2(DATA_W) + 1;
   localparam int CFG_W = $bits(mw_cfg_t);

   initial begin
      assert (DATA_W == 16) else $error("command layout needs DATA_W of 16");
      assert (NUM_CS >= 1 && NUM_CS <= 4) else $error("NUM_CS must be 1 to 4");
      assert (ADDR_SHIFT >= 0 && ADDR_SHIFT <= 4) else $error("ADDR_SHIFT out of range");
   end

   logic [2:0]        idx;
   logic [DATA_W-1:0] tx_q, rx_q, rx_word;
   mw_cfg_t           cfg_all [4];
   logic              clk_en_q, pol_q, cs_cmd_q, ready_q;
   logic [1:0]        psel_q, sel_q;
   logic [CNT_W-1:0]  wcnt_q, rcnt_q, wcnt_in, rcnt_in;
   logic              tick, busy, rx_done, accept, go;
   logic [NUM_CS-1:0] hi_mask;

   function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v);
      return (v > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : v;
   endfunction

   assign idx     = bus_addr[ADDR_W-1:ADDR_SHIFT];
   assign accept  = bus_wr && (idx == 3'd1) && !busy;
   assign go      = accept && bus_wdata[13];
   assign wcnt_in = clamp_cnt(bus_wdata[9:5]);
   assign rcnt_in = clamp_cnt(bus_wdata[4:0]);

   // per-device settings, two per register
   for (genvar i = 0; i < 4; i++) begin : g_cfg
      if (i < NUM_CS) begin : g_on
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_all[i] <= '0;
            else if (bus_wr && idx == 3'(2 + i / 2))
               cfg_all[i] <= mw_cfg_t'(bus_wdata[CFG_W*(i%2) +: CFG_W]);
         end
         assign hi_mask[i] = cfg_all[i].cs_hi;
      end else begin : g_off
         assign cfg_all[i] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q     <= '0;
         rx_q     <= '0;
         clk_en_q <= 1'b0;
         psel_q   <= '0;
         pol_q    <= 1'b0;
         cs_cmd_q <= 1'b0;
         sel_q    <= '0;
         wcnt_q   <= '0;
         rcnt_q   <= '0;
         ready_q  <= 1'b0;
      end else begin
         if (bus_wr && idx == 3'd0) tx_q <= bus_wdata;
         if (bus_wr && idx == 3'd4) {psel_q, clk_en_q} <= bus_wdata[2:0];
         if (bus_wr && idx == 3'd5) pol_q <= bus_wdata[0];
         if (accept) begin
            cs_cmd_q <= bus_wdata[12];
            sel_q    <= bus_wdata[11:10];
            wcnt_q   <= wcnt_in;
            rcnt_q   <= rcnt_in;
         end
         if (rx_done) begin
            rx_q    <= rx_word;
            ready_q <= 1'b1;
         end else if (go || (bus_rd && idx == 3'd0)) begin
            ready_q <= 1'b0;
         end
      end
   end

   always_comb begin
      case (idx)
         3'd0:    bus_rdata = rx_q;
         3'd1:    bus_rdata = {ready_q, busy, 1'b0, cs_cmd_q, sel_q, wcnt_q, rcnt_q};
         3'd2:    bus_rdata = {4'b0, cfg_all[1], cfg_all[0]};
         3'd3:    bus_rdata = {4'b0, cfg_all[3], cfg_all[2]};
         3'd4:    bus_rdata = {13'b0, psel_q, clk_en_q};
         3'd5:    bus_rdata = {15'b0, pol_q};
         default: bus_rdata = '0;
      endcase
   end

   mw_prescale u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (clk_en_q),
      .ratio_sel (psel_q),
      .tick      (tick)
   );

   mw_shift_engine #(.DATA_W(DATA_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .idle_pol  (pol_q),
      .cfg       (cfg_all[sel_q]),
      .start     (go),
      .send_bits (wcnt_in),
      .recv_bits (rcnt_in),
      .tx_word   (tx_q),
      .sdi       (sdi),
      .sclk      (sclk),
      .sdo       (sdo),
      .busy      (busy),
      .rx_done   (rx_done),
      .rx_word   (rx_word)
   );

   mw_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
      .sel_on  (cs_cmd_q),
      .sel_idx (sel_q),
      .hi_mask (hi_mask),
      .cs_out  (cs_out)
   );

   // R9: select lines move only in response to a register write
   a_r9_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(cs_out));
   // R11: data ready appears exactly as busy drops
   a_r11_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $fell(busy));
   // R12: a command written while busy leaves the device index alone
   a_r12_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && idx == 3'd1 && busy) |=> $stable(sel_q));

endmodule

// File: tb/sim_serial_mw_master.sv
`timescale 1ns/1ps
module sim_serial_mw_master;
   localparam int SH = 1;

   logic        clk = 0, rst_n = 0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic        sdi = 0, sclk, sdo;
   logic [3:0]  cs_out;

   serial_mw_master #(.DATA_W(16), .NUM_CS(4), .ADDR_SHIFT(SH)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sdi(sdi), .sclk(sclk), .sdo(sdo), .cs_out(cs_out));

   always #2 clk = ~clk;

   int checks = 0, failures = 0;
   bit finished = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bench-side device model
   bit          mon = 0;
   int          m_w, m_r, m_sel, edge_cnt, cap_n, rd_j, gap_bad, cs_bad, exp_gap;
   bit          m_txr, m_rxr, m_hi;
   logic [15:0] cap_tx, m_pat;
   time         last_t;

   always @(sclk) begin
      #1;
      if (mon) begin
         if (cs_out[m_sel] !== m_hi) cs_bad++;
         if (edge_cnt > 0 && ($time - last_t) != exp_gap) gap_bad++;
         last_t = $time;
         if (edge_cnt < 2*m_w) begin
            if (sclk != m_txr) begin cap_tx = {cap_tx[14:0], sdo}; cap_n++; end
         end else if (edge_cnt < 2*(m_w+m_r)) begin
            if (sclk == m_rxr) begin
               rd_j++;
               if (rd_j < m_r) sdi = m_pat[m_r-1-rd_j];
            end
         end
         edge_cnt++;
      end
   end

   task automatic wr(input int i, input logic [15:0] d);
      @(negedge clk); bus_addr = 4'(i << SH); bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input int i, output logic [15:0] d);
      @(negedge clk); bus_addr = 4'(i << SH); bus_rd = 1; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic peek(input int i, output logic [15:0] d);
      @(negedge clk); bus_addr = 4'(i << SH); #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      for (int k = 0; k < 20000; k++) begin
         peek(1, s);
         if (!s[14]) break;
      end
   endtask

   function automatic int pratio(input logic [1:0] p);
      case (p) 2'd0: return 2; 2'd1: return 4; 2'd2: return 7; default: return 10; endcase
   endfunction
   function automatic int dhalf(input logic [1:0] d);
      case (d) 2'd0: return 1; 2'd1: return 2; default: return 4; endcase
   endfunction
   function automatic int clampc(input int v);
      return (v > 16) ? 16 : v;
   endfunction

   task automatic arm(input int sel, input logic [5:0] cfg, input logic [1:0] ps,
                      input int w, input int r, input logic [15:0] pat);
      m_sel = sel; m_txr = cfg[1]; m_rxr = cfg[0]; m_hi = cfg[2];
      m_w = clampc(w); m_r = clampc(r); m_pat = pat;
      exp_gap = pratio(ps) * dhalf(cfg[4:3]) * 4;
      edge_cnt = 0; cap_n = 0; cap_tx = '0; rd_j = 0; gap_bad = 0; cs_bad = 0;
      sdi = (m_r > 0) ? pat[m_r-1] : 1'b0;
      mon = 1;
   endtask

   typedef struct packed {
      logic [1:0]  sel;
      logic [5:0]  cfg;
      logic [1:0]  ps;
      logic        pol;
      logic [4:0]  w;
      logic [4:0]  r;
      logic [15:0] tx;
      logic [15:0] pat;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 6'b000010, 2'd0, 1'b0, 5'd8,  5'd0,  16'hA500, 16'h0000},
      '{2'd1, 6'b001001, 2'd1, 1'b1, 5'd0,  5'd12, 16'h0000, 16'h0ABC},
      '{2'd2, 6'b010110, 2'd2, 1'b0, 5'd16, 5'd16, 16'h1234, 16'hBEEF},
      '{2'd3, 6'b000001, 2'd3, 1'b1, 5'd1,  5'd1,  16'h8000, 16'h0001},
      '{2'd0, 6'b000011, 2'd0, 1'b0, 5'd5,  5'd3,  16'hB800, 16'h0005},
      '{2'd1, 6'b011000, 2'd0, 1'b1, 5'd20, 5'd0,  16'hC3A5, 16'h0000}
   };

   initial begin
      #(200000 * 4);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] s, d;
      logic [5:0]  cfgs [4];
      int wn, rn;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // reset state
      peek(1, s);
      check("R2 reset status", s, 16'h0000);
      check("R9 reset selects", cs_out, 4'hF);
      check("R8 reset sclk", sclk, 1'b0);

      // R1 register readback and stride
      wr(4, 16'h0005);
      peek(4, d); check("R1 clock setup readback", d, 16'h0005);
      peek(6, d); check("R1 unused index", d, 16'h0000);

      // R9 select without start
      wr(1, 16'h1800);
      check("R9 cs2 active low", cs_out, 4'b1011);
      wr(1, 16'h0800);
      check("R9 cs released", cs_out, 4'b1111);
      wr(3, 16'h0004);
      check("R9 cs2 polarity high idle", cs_out, 4'b1011);
      wr(1, 16'h1800);
      check("R9 cs2 active high", cs_out, 4'b1111);
      wr(3, 16'h0000);

      // vector table
      foreach (VECS[v]) begin
         for (int k = 0; k < 4; k++) cfgs[k] = '0;
         cfgs[VECS[v].sel] = VECS[v].cfg;
         wr(2, {4'b0, cfgs[1], cfgs[0]});
         wr(3, {4'b0, cfgs[3], cfgs[2]});
         wr(4, {13'b0, VECS[v].ps, 1'b1});
         wr(5, {15'b0, VECS[v].pol});
         wr(0, VECS[v].tx);
         repeat (3) @(negedge clk);
         arm(VECS[v].sel, VECS[v].cfg, VECS[v].ps, VECS[v].w, VECS[v].r, VECS[v].pat);
         wn = clampc(VECS[v].w); rn = clampc(VECS[v].r);
         wr(1, {2'b0, 1'b1, 1'b1, VECS[v].sel, VECS[v].w, VECS[v].r});
         wait_idle();
         @(negedge clk); mon = 0;
         if (wn > 0) begin
            check($sformatf("R3 sent word v%0d", v), cap_tx, 16'(VECS[v].tx >> (16 - wn)));
            check($sformatf("R3 sent bits v%0d", v), cap_n, wn);
         end
         check($sformatf("R5 edge count v%0d", v), edge_cnt, 2*(wn+rn));
         check($sformatf("R6 half period v%0d", v), gap_bad, 0);
         check($sformatf("R9 cs during transfer v%0d", v), cs_bad, 0);
         check($sformatf("R8 rest level v%0d", v), sclk, VECS[v].pol);
         peek(1, s);
         check($sformatf("R13 status counts v%0d", v), {s[11:0]},
               {VECS[v].sel, 5'(wn), 5'(rn)});
         check($sformatf("R11 ready after v%0d", v), s[15], (rn > 0));
         if (rn > 0) begin
            rd(0, d);
            check($sformatf("R4 received word v%0d", v), d, 16'(VECS[v].pat & ((1 << rn) - 1)));
            peek(1, s);
            check($sformatf("R11 ready cleared by read v%0d", v), s[15], 1'b0);
         end
      end

      // R10 zero-count start
      arm(0, 6'b000000, 2'd0, 0, 0, 16'h0);
      wr(1, 16'h3000);
      peek(1, s); check("R10 zero count not busy", s[14], 1'b0);
      repeat (20) @(negedge clk);
      check("R10 zero count no edges", edge_cnt, 0);
      mon = 0;

      // R11 ready cleared by a new start
      wr(2, 16'h0000); wr(4, 16'h0001); wr(5, 16'h0000);
      arm(0, 6'b000000, 2'd0, 0, 2, 16'h0003);
      wr(1, 16'h3002);
      wait_idle(); mon = 0;
      peek(1, s); check("R11 ready set", s[15], 1'b1);
      wr(1, 16'h3100);
      peek(1, s); check("R11 ready cleared by start", s[15], 1'b0);
      wait_idle();

      // R7 gated clock
      wr(4, 16'h0000); wr(0, 16'h9000);
      arm(0, 6'b000000, 2'd0, 4, 0, 16'h0);
      wr(1, 16'h3080);
      repeat (100) @(negedge clk);
      peek(1, s); check("R7 waits while gated", s[14], 1'b1);
      check("R7 no edges while gated", edge_cnt, 0);
      wr(4, 16'h0001);
      wait_idle(); mon = 0;
      check("R7 resumed word", cap_tx, 16'h0009);

      // R12 command while busy
      wr(2, 16'h0010); wr(0, 16'h5A00);
      arm(0, 6'b010000, 2'd0, 8, 0, 16'h0);
      wr(1, 16'h3100);
      wr(1, 16'h3C05);
      wait_idle(); mon = 0;
      peek(1, s);
      check("R12 ignored fields", s[12:0], 13'h1100);
      check("R12 no extra transfer", edge_cnt, 16);
      check("R10 busy low at end", s[14], 1'b0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule